// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block owns the 32-bit control and status word of a floating-point unit. Every time the arithmetic pipeline completes an operation it presents that operation's exception outcome on a result port, qualified by a valid strobe, a request to write a result back, and, for compare operations, a condition-bit selector and the compare outcome. The block replaces the per-operation cause bits and accumulates the sticky flags. It then decides whether a trap must be raised. A trap suppresses the register-file write and any condition-bit update.

Software updates the word through a write port and sees it on a read port. Only the rounding mode, the flags, the enables and the flush-to-zero control are writable; all other bits keep their value. After a software write the trap condition is checked again, so enabling an exception whose cause bit is already set traps at once. When a software write and an operation land in the same cycle, the write is applied first and the operation's outcome is layered on top.

Top module: `fp_status_unit`

## Requirements
- R1: A synchronous reset clears the whole word to zero and holds trap_o and wb_commit_o low in the cycle after it.
- R2: The rounding mode sits in bits [1:0] (0 nearest, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity). It is writable by software, and rnd_mode always shows bits [1:0] of the word.
- R3: Each valid operation overwrites cause bits [17:12] with {op_unimpl, op_exc}. op_exc holds bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid, and bit 17 is the unimplemented cause.
- R4: Each valid operation ORs op_exc into the sticky flags [6:2], in the same order as op_exc. An operation never clears a flag.
- R5: trap_o pulses in the cycle after an event (a software write or a valid operation) when cause bit 12+k and enable bit 7+k are both set for some k in 0..4, or when cause bit 17 is set. Cause bit 17 has no enable bit.
- R6: wb_commit_o pulses in the cycle after a valid non-compare operation with op_wb_req set, unless that operation traps. A trapping operation still updates cause and flags.
- R7: A software write changes only bit 24 (flush), bits [11:7] (enables), bits [6:2] (flags) and bits [1:0]. Every other bit keeps its value.
- R8: The trap check also runs after a software write on its own, so setting an enable bit whose cause bit is already set raises trap_o.
- R9: A non-trapping valid compare writes op_cc_val into the selected condition bit only. Condition 0 is at bit 23 and condition k (1..7) is at bit 24+k. A trapping compare leaves all condition bits unchanged.
- R10: When a software write and a valid operation occur in the same cycle, the operation's cause, flag and condition updates apply on top of the written value. The trap check uses the combined result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| op_valid | input | 1 | Completed-operation strobe |
| op_exc | input | 5 | Exceptions of the operation (inexact, underflow, overflow, divide-by-zero, invalid) |
| op_unimpl | input | 1 | Operation could not be completed in hardware |
| op_wb_req | input | 1 | Operation has a result to write to the register file |
| op_is_cmp | input | 1 | Operation is a compare |
| op_cc_sel | input | 3 | Condition bit selected by a compare |
| op_cc_val | input | 1 | Compare outcome |
| csr_rdata | output | 32 | Current control and status word |
| rnd_mode | output | 2 | Current rounding mode |
| trap_o | output | 1 | Trap request, one cycle after the event |
| wb_commit_o | output | 1 | Result may be written to the register file |

## Verification
The assertions take it for granted that a compare carries no write-back request that matters: wb_commit_o is checked low for compares whatever op_wb_req says. They also assume that operation strobes last one cycle, and that condition and cause bits change only through the paths listed above. Outside reset nothing else touches the word. The stimulus drives each event for exactly one cycle with idle cycles between events. Same-cycle write-and-operation cases are made only on purpose, to check the ordering rule.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned CSR_W     = 32;
  localparam int unsigned EXC_N     = 5;
  localparam int unsigned CAUSE_W   = EXC_N + 1;
  localparam int unsigned RM_W      = 2;
  localparam int unsigned RM_LSB    = 0;
  localparam int unsigned FLAG_LSB  = 2;
  localparam int unsigned EN_LSB    = FLAG_LSB + EXC_N;
  localparam int unsigned CAUSE_LSB = EN_LSB + EXC_N;
  localparam int unsigned CC0_POS   = 23;
  localparam int unsigned FLUSH_POS = 24;
  localparam int unsigned CCHI_LSB  = 25;
  localparam int unsigned CC_N      = 8;
  localparam int unsigned CC_SEL_W  = $clog2(CC_N);

  function automatic int unsigned cc_pos(int unsigned k);
    return (k == 0) ? CC0_POS : CCHI_LSB + k - 1;
  endfunction

  function automatic logic [CC_N-1:0] cc_of(logic [CSR_W-1:0] v);
    logic [CC_N-1:0] r;
    for (int unsigned k = 0; k < CC_N; k++) r[k] = v[cc_pos(k)];
    return r;
  endfunction

  function automatic logic [CSR_W-1:0] wr_mask();
    logic [CSR_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < RM_W; i++)  m[RM_LSB + i]   = 1'b1;
    for (int unsigned i = 0; i < EXC_N; i++) m[FLAG_LSB + i] = 1'b1;
    for (int unsigned i = 0; i < EXC_N; i++) m[EN_LSB + i]   = 1'b1;
    m[FLUSH_POS] = 1'b1;
    return m;
  endfunction

  localparam logic [CSR_W-1:0] WR_MASK = wr_mask();
endpackage

// File: rtl/fpsr_sw_merge.sv
module fpsr_sw_merge
  import fpsr_pkg::*;
#(
  parameter int unsigned W = CSR_W
) (
  input  logic [W-1:0] cur,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] merged
);
  localparam logic [W-1:0] MASK = W'(WR_MASK);

  always_comb begin
    merged = cur;
    if (wr_en) merged = (cur & ~MASK) | (wr_data & MASK);
  end
endmodule

// File: rtl/fpsr_op_apply.sv
module fpsr_op_apply
  import fpsr_pkg::*;
#(
  parameter int unsigned W  = CSR_W,
  parameter int unsigned NE = EXC_N
) (
  input  logic [W-1:0]  base,
  input  logic          valid,
  input  logic [NE-1:0] exc,
  input  logic          unimpl,
  output logic [W-1:0]  applied
);
  always_comb begin
    applied = base;
    if (valid) begin
      applied[CAUSE_LSB +: NE+1] = {unimpl, exc};
      applied[FLAG_LSB +: NE]    = base[FLAG_LSB +: NE] | exc;
    end
  end
endmodule

// File: rtl/fpsr_trap_eval.sv
module fpsr_trap_eval
  import fpsr_pkg::*;
#(
  parameter int unsigned NE = EXC_N
) (
  input  logic          evt,
  input  logic [NE:0]   cause,
  input  logic [NE-1:0] enables,
  output logic          trap
);
  logic enabled_hit;
  assign enabled_hit = |(cause[NE-1:0] & enables);
  assign trap        = evt & (enabled_hit | cause[NE]);
endmodule

// File: rtl/fpsr_cc_update.sv
module fpsr_cc_update
  import fpsr_pkg::*;
#(
  parameter int unsigned W  = CSR_W,
  parameter int unsigned NC = CC_N,
  parameter int unsigned SW = CC_SEL_W
) (
  input  logic [W-1:0]  base,
  input  logic          en,
  input  logic [SW-1:0] sel,
  input  logic          val,
  output logic [W-1:0]  updated
);
  logic [NC-1:0] hit;

  for (genvar k = 0; k < NC; k++) begin : g_hit
    assign hit[k] = en && (sel == SW'(k));
  end

  always_comb begin
    updated = base;
    for (int unsigned k = 0; k < NC; k++) begin
      if (hit[k]) updated[cc_pos(k)] = val;
    end
  end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_wr_en,
  input  logic [CSR_W-1:0]    sw_wr_data,
  input  logic                op_valid,
  input  logic [EXC_N-1:0]    op_exc,
  input  logic                op_unimpl,
  input  logic                op_wb_req,
  input  logic                op_is_cmp,
  input  logic [CC_SEL_W-1:0] op_cc_sel,
  input  logic                op_cc_val,
  output logic [CSR_W-1:0]    csr_rdata,
  output logic [RM_W-1:0]     rnd_mode,
  output logic                trap_o,
  output logic                wb_commit_o
);
  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] after_sw;
  logic [CSR_W-1:0] after_op;
  logic [CSR_W-1:0] csr_nx;
  logic             trap_nx;
  logic             commit_nx;
  logic             evt;

  assign evt = sw_wr_en | op_valid;

  fpsr_sw_merge #(.W(CSR_W)) u_merge (
    .cur(csr_q), .wr_en(sw_wr_en), .wr_data(sw_wr_data), .merged(after_sw)
  );

  fpsr_op_apply #(.W(CSR_W), .NE(EXC_N)) u_apply (
    .base(after_sw), .valid(op_valid), .exc(op_exc), .unimpl(op_unimpl),
    .applied(after_op)
  );

  fpsr_trap_eval #(.NE(EXC_N)) u_trap (
    .evt(evt),
    .cause(after_op[CAUSE_LSB +: CAUSE_W]),
    .enables(after_op[EN_LSB +: EXC_N]),
    .trap(trap_nx)
  );

  fpsr_cc_update #(.W(CSR_W), .NC(CC_N), .SW(CC_SEL_W)) u_cc (
    .base(after_op), .en(op_valid & op_is_cmp & ~trap_nx),
    .sel(op_cc_sel), .val(op_cc_val), .updated(csr_nx)
  );

  assign commit_nx = op_valid & op_wb_req & ~op_is_cmp & ~trap_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q       <= '0;
      trap_o      <= 1'b0;
      wb_commit_o <= 1'b0;
    end else begin
      csr_q       <= csr_nx;
      trap_o      <= trap_nx;
      wb_commit_o <= commit_nx;
    end
  end

  assign csr_rdata = csr_q;
  assign rnd_mode  = csr_q[RM_LSB +: RM_W];

  // R1: reset leaves a zero word and no pulses
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (csr_q == '0 && !trap_o && !wb_commit_o));

  // R3: cause field mirrors the last operation's outcome
  a_r3_cause_replaced: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> csr_q[CAUSE_LSB +: CAUSE_W] == $past({op_unimpl, op_exc}));

  // R4: without a software write no flag is lost
  a_r4_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !sw_wr_en |=> (($past(csr_q[FLAG_LSB +: EXC_N]) & ~csr_q[FLAG_LSB +: EXC_N]) == '0));

  // R6: a trap and a commit never coincide
  a_r6_trap_blocks_wb: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !wb_commit_o);

  // R6: compares never commit a result
  a_r6_cmp_no_commit: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_is_cmp) |=> !wb_commit_o);

  // R7: a lone software write leaves protected bits untouched
  a_r7_protected_bits: assert property (@(posedge clk) disable iff (rst)
    (sw_wr_en && !op_valid) |=> (((csr_q ^ $past(csr_q)) & ~WR_MASK) == '0));

  // R9: compare touches only the selected condition bit
  a_r9_cc_select_only: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_is_cmp) |=>
      (((cc_of(csr_q) ^ $past(cc_of(csr_q))) & ~(CC_N'(1) << $past(op_cc_sel))) == '0));

  // R9: a trapping compare keeps all condition bits
  a_r9_trap_keeps_cc: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_is_cmp) |=> (!trap_o || cc_of(csr_q) == $past(cc_of(csr_q))));

  // R5: no trap without an event
  a_r5_trap_needs_event: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr_en && !op_valid) |=> !trap_o);
endmodule

// File: tb/fp_status_unit_tb_top.sv
module fp_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        sw_wr_en;
  logic [31:0] sw_wr_data;
  logic        op_valid;
  logic [4:0]  op_exc;
  logic        op_unimpl;
  logic        op_wb_req;
  logic        op_is_cmp;
  logic [2:0]  op_cc_sel;
  logic        op_cc_val;
  logic [31:0] csr_rdata;
  logic [1:0]  rnd_mode;
  logic        trap_o;
  logic        wb_commit_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_status_unit dut_i (
    .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .op_valid(op_valid), .op_exc(op_exc), .op_unimpl(op_unimpl),
    .op_wb_req(op_wb_req), .op_is_cmp(op_is_cmp), .op_cc_sel(op_cc_sel),
    .op_cc_val(op_cc_val), .csr_rdata(csr_rdata), .rnd_mode(rnd_mode),
    .trap_o(trap_o), .wb_commit_o(wb_commit_o)
  );

  typedef struct {
    string       tag;
    logic [31:0] csr;
    logic        trap;
    logic        commit;
  } exp_t;

  exp_t        sb_q[$];
  int          total = 0;
  int          bad   = 0;
  logic [31:0] model = '0;
  bit          done  = 0;

  localparam logic [31:0] WMASK = 32'h0100_0FFF;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int ccbit(int k);
    return (k == 0) ? 23 : 24 + k;
  endfunction

  task automatic ev(string tag, bit sw, logic [31:0] wd, bit v, logic [4:0] e,
                    bit un, bit wb, bit cmp, int sel, bit cv);
    exp_t  x;
    logic [31:0] m;
    bit tr;
    @(negedge clk);
    sw_wr_en = sw; sw_wr_data = wd; op_valid = v; op_exc = e;
    op_unimpl = un; op_wb_req = wb; op_is_cmp = cmp;
    op_cc_sel = 3'(sel); op_cc_val = cv;
    m = model;
    if (sw) m = (m & ~WMASK) | (wd & WMASK);
    if (v) begin
      m[17:12] = {un, e};
      m[6:2]   = m[6:2] | e;
    end
    tr = (sw || v) && ((|(m[16:12] & m[11:7])) || m[17]);
    if (v && cmp && !tr) m[ccbit(sel)] = cv;
    model    = m;
    x.tag    = tag;
    x.csr    = m;
    x.trap   = tr;
    x.commit = v && wb && !cmp && !tr;
    @(posedge clk);
    sb_q.push_back(x);
    @(negedge clk);
    sw_wr_en = 0; op_valid = 0;
  endtask

  task automatic op(string tag, logic [4:0] e, bit un, bit wb);
    ev(tag, 0, '0, 1, e, un, wb, 0, 0, 0);
  endtask

  task automatic wr(string tag, logic [31:0] d);
    ev(tag, 1, d, 0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic cmpop(string tag, logic [4:0] e, int sel, bit cv);
    ev(tag, 0, '0, 1, e, 0, 1, 1, sel, cv);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        chk(x.tag, "csr", csr_rdata, x.csr);
        chk(x.tag, "trap", {31'd0, trap_o}, {31'd0, x.trap});
        chk(x.tag, "commit", {31'd0, wb_commit_o}, {31'd0, x.commit});
        chk(x.tag, "rnd_mode", {30'd0, rnd_mode}, {30'd0, x.csr[1:0]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; sw_wr_en = 0; sw_wr_data = '0; op_valid = 0; op_exc = '0;
    op_unimpl = 0; op_wb_req = 0; op_is_cmp = 0; op_cc_sel = '0; op_cc_val = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "csr", csr_rdata, 32'h0);
    chk("R1", "trap", {31'd0, trap_o}, 32'h0);
    chk("R1", "commit", {31'd0, wb_commit_o}, 32'h0);

    // R7: all-ones write reaches only writable bits
    wr("R7", 32'hFFFF_FFFF);
    // R2: each rounding mode
    wr("R2", 32'h0000_0001);
    wr("R2", 32'h0000_0002);
    wr("R2", 32'h0000_0000);
    // R3 R4 R6: plain operations, no enables
    op("R3", 5'b00001, 0, 1);
    op("R3", 5'b00100, 0, 1);
    op("R4", 5'b00000, 0, 1);
    op("R4", 5'b10010, 0, 0);
    // R8: enable overflow while its cause is set
    op("R8", 5'b00100, 0, 1);
    wr("R8", 32'h0000_0200);
    // R7: write cannot clear cause or conditions
    wr("R7", 32'h0000_0000);
    // R5 R6: enabled divide-by-zero traps and blocks commit
    wr("R5", 32'h0000_0400);
    op("R6", 5'b01000, 0, 1);
    op("R6", 5'b00001, 0, 1);
    // R5: unimplemented always traps with no enables
    wr("R5", 32'h0000_0000);
    op("R5", 5'b00000, 1, 1);
    op("R5", 5'b00000, 0, 1);
    // R9: compares
    cmpop("R9", 5'b0, 0, 1);
    cmpop("R9", 5'b0, 5, 1);
    cmpop("R9", 5'b0, 7, 1);
    cmpop("R9", 5'b0, 0, 0);
    cmpop("R9", 5'b0, 1, 1);
    wr("R9", 32'h0000_0800);
    cmpop("R9", 5'b10000, 3, 1);
    cmpop("R9", 5'b10000, 5, 0);
    cmpop("R9", 5'b00001, 5, 0);
    // R10: write and operation together
    ev("R10", 1, 32'h0100_0083, 1, 5'b00010, 0, 1, 0, 0, 0);
    ev("R10", 1, 32'h0000_0003, 1, 5'b00010, 0, 1, 0, 0, 0);
    ev("R10", 1, 32'h0000_0000, 1, 5'b00000, 0, 0, 1, 6, 1);

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule